// File: doc/BRIEF.md
# Zero Common-Mode Switching-State Selector

This block is the decision core of a predictive controller for a three-by-three direct matrix converter. It only considers the six switching states that tie each output phase to a different input phase. In each of these states the sum of the three output voltages is zero, so the common-mode voltage is zero whichever state wins. The cost therefore does not need a common-mode term. It weighs only how well each state would track the load-current and source-current references.

A start pulse captures one sampling period's worth of inputs. These are:
- the three input-side phase voltages and the three load currents;
- the load-current references and the source-current references;
- the candidate-independent part of the source-current prediction;
- three model coefficients and a weighting factor.

The block then scores one candidate per clock cycle. For each candidate it:
1. routes the voltages and currents through that candidate's switch matrix;
2. predicts the next load and source currents;
3. converts both error vectors to alpha-beta form;
4. forms a weighted sum of squares.

After the sixth candidate it registers the winning index and its nine-bit switch matrix, and pulses `done`.

Top module: `zcm_selector`

## Requirements
- R1: Candidate index i selects the input phase (0=a, 1=b, 2=c) for output phases A, B, C as follows:
  - 0 → abc
  - 1 → acb
  - 2 → cab
  - 3 → bac
  - 4 → bca
  - 5 → cba

  Switch-matrix bit 3*o+n is set when output o (0=A, 1=B, 2=C) connects to input n. Exactly one bit is set per output and per input.
- R2: For the candidate under evaluation, output voltage o equals the input voltage its switch selects. Input current n equals the load current of the output phase connected to input n.
- R3: The predicted load current of phase o is (k_volt*u_o + k_load*il_o) >>> FRAC, where FRAC=14 by default. The load error is that prediction minus the load reference.
- R4: The predicted source current of phase n is isp_n + ((k_src*ie_n) >>> FRAC). The source error is that prediction minus the source reference.
- R5: Each error vector (x0, x1, x2) is mapped to alpha = ((2*x0 - x1 - x2)*5461) >>> 14 and beta = ((x1 - x2)*9459) >>> 14.
- R6: Cost = alpha_l² + beta_l² + ((lambda_w*(alpha_s² + beta_s²)) >> 14). lambda_w is an unsigned weight with 16384 meaning 1.0, so 8192 means 0.5.
- R7: The candidate with the smallest cost is selected. When costs are equal, the lower index wins.
- R8: `done` is high for exactly one cycle, on the sixth rising edge after the edge that accepts `start`. `best_idx` and `best_sw` change only in the cycle in which `done` is high.
- R9: Inputs are captured at the edge that accepts `start`. Later input changes do not affect the result. A `start` pulse that arrives while an evaluation is running is ignored.
- R10: During and after reset, `done` is 0, `best_idx` is 0 and `best_sw` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin evaluation of the presented sample |
| ue_a | input | DW | Input-side voltage, phase a |
| ue_b | input | DW | Input-side voltage, phase b |
| ue_c | input | DW | Input-side voltage, phase c |
| il_a | input | DW | Load current, output A |
| il_b | input | DW | Load current, output B |
| il_c | input | DW | Load current, output C |
| il_ref_a | input | DW | Load current reference, A |
| il_ref_b | input | DW | Load current reference, B |
| il_ref_c | input | DW | Load current reference, C |
| isp_a | input | DW | Candidate-independent source prediction, a |
| isp_b | input | DW | Candidate-independent source prediction, b |
| isp_c | input | DW | Candidate-independent source prediction, c |
| is_ref_a | input | DW | Source current reference, a |
| is_ref_b | input | DW | Source current reference, b |
| is_ref_c | input | DW | Source current reference, c |
| k_volt | input | CW | Load voltage coefficient, signed Q(FRAC) |
| k_load | input | CW | Load current decay coefficient, signed Q(FRAC) |
| k_src | input | CW | Source gain on input current, signed Q(FRAC) |
| lambda_w | input | CW | Unsigned source-error weight, Q(FRAC) |
| done | output | 1 | One-cycle result-valid pulse |
| best_idx | output | 3 | Index of the winning candidate |
| best_sw | output | 9 | Switch matrix of the winning candidate |

## Verification
A candidate counter that is out of step, or a corrupted running minimum, shows at the ports as a wrong `best_idx` together with a matching but wrong `best_sw`. It becomes visible at the very next `done` pulse, six cycles after the start that exposed it. A broken sequencing state shows as `done` arriving at the wrong distance from `start`, a retrigger, or outputs moving between pulses, and it is caught in the same evaluation window. The directed cases use references that only one candidate matches exactly, so a routing or transpose error moves the winner on the first run that targets that candidate.

// File: rtl/zcm_pkg.sv
// Package: shared state type and the permutation decoding of the six
// zero common-mode candidates. Assumes candidate indices 0..5.
package zcm_pkg;

    typedef enum logic {ST_IDLE, ST_RUN} zcm_state_t;

    localparam int unsigned NCAND = 6;

    // Input phase chosen by each output; field [2j+1:2j] belongs to output j.
    function automatic logic [5:0] perm_code(input logic [2:0] idx);
        case (idx)
            3'd0:    perm_code = {2'd2, 2'd1, 2'd0};
            3'd1:    perm_code = {2'd1, 2'd2, 2'd0};
            3'd2:    perm_code = {2'd1, 2'd0, 2'd2};
            3'd3:    perm_code = {2'd2, 2'd0, 2'd1};
            3'd4:    perm_code = {2'd0, 2'd2, 2'd1};
            3'd5:    perm_code = {2'd0, 2'd1, 2'd2};
            default: perm_code = {2'd2, 2'd1, 2'd0};
        endcase
    endfunction

    // Nine-bit switch matrix: bit 3*out + in.
    function automatic logic [8:0] perm_matrix(input logic [2:0] idx);
        logic [5:0] code;
        code = perm_code(idx);
        perm_matrix = '0;
        for (int j = 0; j < 3; j++) begin
            perm_matrix[3*j + int'(code[2*j +: 2])] = 1'b1;
        end
    endfunction

endpackage

// File: rtl/zcm_route.sv
// Routes voltages and currents through one candidate's switch matrix.
// Assumes idx in 0..5; output j takes the input its switch selects, and
// each input current is the load current of the output tied to it.
module zcm_route
    import zcm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [2:0]          idx,
    input  logic signed [DW-1:0] ue [3],
    input  logic signed [DW-1:0] io [3],
    output logic signed [DW-1:0] uo [3],
    output logic signed [DW-1:0] ie [3]
);
    logic [5:0] code;
    assign code = perm_code(idx);

    // Output voltage routing, one selector per output phase.
    for (genvar j = 0; j < 3; j++) begin : g_out
        assign uo[j] = ue[code[2*j +: 2]];
    end

    // Transposed routing of load currents back onto the input phases.
    always_comb begin
        for (int n = 0; n < 3; n++) begin
            ie[n] = '0;
            for (int j = 0; j < 3; j++) begin
                if (code[2*j +: 2] == 2'(n)) ie[n] = io[j];
            end
        end
    end
endmodule

// File: rtl/zcm_predict.sv
// One-step predictions of load and source currents for one candidate and
// their errors against the references. Coefficients are signed Q(FRAC);
// results are widened to EW bits so no intermediate wraps.
module zcm_predict #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int EW   = DW + 4
) (
    input  logic signed [DW-1:0] uo     [3],
    input  logic signed [DW-1:0] io     [3],
    input  logic signed [DW-1:0] ie     [3],
    input  logic signed [DW-1:0] io_ref [3],
    input  logic signed [DW-1:0] is_pre [3],
    input  logic signed [DW-1:0] is_ref [3],
    input  logic signed [CW-1:0] k_volt,
    input  logic signed [CW-1:0] k_load,
    input  logic signed [CW-1:0] k_src,
    output logic signed [EW-1:0] err_ld [3],
    output logic signed [EW-1:0] err_sr [3]
);
    localparam int PW = DW + CW;

    for (genvar j = 0; j < 3; j++) begin : g_ph
        logic signed [PW-1:0] p_u, p_i, p_s;
        logic signed [PW:0]   p_sum;
        logic signed [EW-1:0] ld_pred, sr_pred;

        // Load model: weighted voltage plus decayed present current.
        always_comb begin
            p_u     = k_volt * uo[j];
            p_i     = k_load * io[j];
            p_sum   = (PW+1)'(p_u) + (PW+1)'(p_i);
            ld_pred = EW'(p_sum >>> FRAC);
            err_ld[j] = ld_pred - EW'(io_ref[j]);
        end

        // Source model: precomputed part plus gain on routed input current.
        always_comb begin
            p_s     = k_src * ie[j];
            sr_pred = EW'(is_pre[j]) + EW'(p_s >>> FRAC);
            err_sr[j] = sr_pred - EW'(is_ref[j]);
        end
    end
endmodule

// File: rtl/zcm_clarke.sv
// Three-phase to alpha-beta conversion with Q(FRAC) constants 1/3 and
// 1/sqrt(3). Assumes the input vector fits EW bits; output is EW+2 bits.
module zcm_clarke #(
    parameter int EW   = 20,
    parameter int CW   = 16,
    parameter int FRAC = 14
) (
    input  logic signed [EW-1:0]   x [3],
    output logic signed [EW+1:0]   alpha,
    output logic signed [EW+1:0]   beta
);
    localparam int AW = EW + 2;
    localparam logic signed [CW-1:0] K_THIRD = CW'(int'((2.0 ** FRAC) / 3.0));
    localparam logic signed [CW-1:0] K_RT3   = CW'(int'((2.0 ** FRAC) * 0.5773502691896258));

    logic signed [AW-1:0]    xa, xb, xc, s_a, s_b;
    logic signed [AW+CW-1:0] p_a, p_b;

    // Scaled difference sums and their fixed-point products.
    always_comb begin
        xa    = AW'(x[0]);
        xb    = AW'(x[1]);
        xc    = AW'(x[2]);
        s_a   = (xa <<< 1) - xb - xc;
        s_b   = xb - xc;
        p_a   = s_a * K_THIRD;
        p_b   = s_b * K_RT3;
        alpha = AW'(p_a >>> FRAC);
        beta  = AW'(p_b >>> FRAC);
    end
endmodule

// File: rtl/zcm_cost.sv
// Quadratic cost: load alpha-beta energy plus lambda-weighted source energy.
// Assumes lambda is non-negative Q(FRAC); cost is unsigned QW bits.
module zcm_cost #(
    parameter int AW   = 22,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int QW   = 2*AW + 2
) (
    input  logic signed [AW-1:0] ld_alpha,
    input  logic signed [AW-1:0] ld_beta,
    input  logic signed [AW-1:0] sr_alpha,
    input  logic signed [AW-1:0] sr_beta,
    input  logic        [CW-1:0] lambda_w,
    output logic        [QW-1:0] cost
);
    logic signed [2*AW-1:0] sq_la, sq_lb, sq_sa, sq_sb;
    logic        [2*AW:0]   e_ld, e_sr;
    logic        [2*AW+CW:0] e_w;

    // Squares, sums and the weighted combination.
    always_comb begin
        sq_la = ld_alpha * ld_alpha;
        sq_lb = ld_beta  * ld_beta;
        sq_sa = sr_alpha * sr_alpha;
        sq_sb = sr_beta  * sr_beta;
        e_ld  = (2*AW+1)'($unsigned(sq_la)) + (2*AW+1)'($unsigned(sq_lb));
        e_sr  = (2*AW+1)'($unsigned(sq_sa)) + (2*AW+1)'($unsigned(sq_sb));
        e_w   = e_sr * lambda_w;
        cost  = QW'(e_ld) + QW'(e_w >> FRAC);
    end
endmodule

// File: rtl/zcm_selector.sv
// Top: captures one sample on start, scores the six zero common-mode
// candidates one per cycle, keeps the running minimum (lower index on ties)
// and publishes index and switch matrix with a one-cycle done pulse.
// Assumes start is ignored while an evaluation is running.
module zcm_selector
    import zcm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] ue_a,
    input  logic signed [DW-1:0] ue_b,
    input  logic signed [DW-1:0] ue_c,
    input  logic signed [DW-1:0] il_a,
    input  logic signed [DW-1:0] il_b,
    input  logic signed [DW-1:0] il_c,
    input  logic signed [DW-1:0] il_ref_a,
    input  logic signed [DW-1:0] il_ref_b,
    input  logic signed [DW-1:0] il_ref_c,
    input  logic signed [DW-1:0] isp_a,
    input  logic signed [DW-1:0] isp_b,
    input  logic signed [DW-1:0] isp_c,
    input  logic signed [DW-1:0] is_ref_a,
    input  logic signed [DW-1:0] is_ref_b,
    input  logic signed [DW-1:0] is_ref_c,
    input  logic signed [CW-1:0] k_volt,
    input  logic signed [CW-1:0] k_load,
    input  logic signed [CW-1:0] k_src,
    input  logic        [CW-1:0] lambda_w,
    output logic                 done,
    output logic [2:0]           best_idx,
    output logic [8:0]           best_sw
);
    localparam int EW = DW + 4;
    localparam int AW = EW + 2;
    localparam int QW = 2*AW + 2;
    localparam logic [2:0] LAST = 3'(NCAND - 1);

    zcm_state_t           state;
    logic [2:0]           cnt;
    logic [QW-1:0]        best_cost;
    logic [2:0]           best_run;
    logic signed [DW-1:0] ue_q [3], il_q [3], ilr_q [3], isp_q [3], isr_q [3];
    logic signed [CW-1:0] kv_q, kl_q, ks_q;
    logic        [CW-1:0] lam_q;

    logic signed [DW-1:0] uo [3], ie [3];
    logic signed [EW-1:0] err_ld [3], err_sr [3];
    logic signed [AW-1:0] la, lb, sa, sb;
    logic [QW-1:0]        cost;
    logic                 take;
    logic [2:0]           winner;

    // Sample capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 3; p++) begin
                ue_q[p] <= '0; il_q[p] <= '0; ilr_q[p] <= '0;
                isp_q[p] <= '0; isr_q[p] <= '0;
            end
            kv_q <= '0; kl_q <= '0; ks_q <= '0; lam_q <= '0;
        end else if (state == ST_IDLE && start) begin
            ue_q  <= '{ue_a, ue_b, ue_c};
            il_q  <= '{il_a, il_b, il_c};
            ilr_q <= '{il_ref_a, il_ref_b, il_ref_c};
            isp_q <= '{isp_a, isp_b, isp_c};
            isr_q <= '{is_ref_a, is_ref_b, is_ref_c};
            kv_q  <= k_volt;
            kl_q  <= k_load;
            ks_q  <= k_src;
            lam_q <= lambda_w;
        end
    end

    zcm_route #(.DW(DW)) u_route (
        .idx(cnt), .ue(ue_q), .io(il_q), .uo(uo), .ie(ie)
    );

    zcm_predict #(.DW(DW), .CW(CW), .FRAC(FRAC), .EW(EW)) u_predict (
        .uo(uo), .io(il_q), .ie(ie), .io_ref(ilr_q), .is_pre(isp_q),
        .is_ref(isr_q), .k_volt(kv_q), .k_load(kl_q), .k_src(ks_q),
        .err_ld(err_ld), .err_sr(err_sr)
    );

    zcm_clarke #(.EW(EW), .CW(CW), .FRAC(FRAC)) u_clarke_ld (
        .x(err_ld), .alpha(la), .beta(lb)
    );

    zcm_clarke #(.EW(EW), .CW(CW), .FRAC(FRAC)) u_clarke_sr (
        .x(err_sr), .alpha(sa), .beta(sb)
    );

    zcm_cost #(.AW(AW), .CW(CW), .FRAC(FRAC), .QW(QW)) u_cost (
        .ld_alpha(la), .ld_beta(lb), .sr_alpha(sa), .sr_beta(sb),
        .lambda_w(lam_q), .cost(cost)
    );

    // Strictly smaller cost replaces the minimum, so ties keep the lower index.
    assign take   = (cnt == 3'd0) || (cost < best_cost);
    assign winner = take ? cnt : best_run;

    // Sequencer, running minimum and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            best_cost <= '0;
            best_run  <= '0;
            done      <= 1'b0;
            best_idx  <= '0;
            best_sw   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    if (take) begin
                        best_cost <= cost;
                        best_run  <= cnt;
                    end
                    if (cnt == LAST) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        best_idx <= winner;
                        best_sw  <= perm_matrix(winner);
                    end else begin
                        cnt <= cnt + 3'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/zcm_selector_chk.sv
// Checker bound to the selector: keeps its own count of the evaluation
// window from start and done, and checks result shape and timing.
module zcm_selector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       done,
    input logic [2:0] best_idx,
    input logic [8:0] best_sw
);
    logic       run_m;
    logic [2:0] n_m;

    // Observer window: six cycles following an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_m <= 1'b0;
            n_m   <= '0;
        end else if (!run_m) begin
            if (start) begin
                run_m <= 1'b1;
                n_m   <= '0;
            end
        end else if (n_m == 3'd5) begin
            run_m <= 1'b0;
        end else begin
            n_m <= n_m + 3'd1;
        end
    end

    AST_DONE_AFTER_SIX: assert property (@(posedge clk) disable iff (!rst_n)
        (run_m && n_m == 3'd5) |=> done);                                  // R8
    AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_m && n_m == 3'd5) |=> !done);                                // R9
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_idx) && $stable(best_sw)));                // R8
    AST_SW_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($onehot(best_sw[2:0]) && $onehot(best_sw[5:3]) && $onehot(best_sw[8:6])
                  && $onehot({best_sw[6], best_sw[3], best_sw[0]})
                  && $onehot({best_sw[7], best_sw[4], best_sw[1]})
                  && $onehot({best_sw[8], best_sw[5], best_sw[2]})));       // R1

    // Index never leaves the candidate range.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            AST_IDX_RANGE: assert (best_idx <= 3'd5);                          // R1
        end
    end
endmodule

bind zcm_selector zcm_selector_chk u_zcm_selector_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .best_idx(best_idx), .best_sw(best_sw)
);

// File: tb/test_zcm_selector.sv
module test_zcm_selector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [15:0] ue [3], il [3], ir [3], isp [3], sr [3];
    logic signed [15:0] kv, kl, ks;
    logic [15:0] lam;
    logic done;
    logic [2:0] best_idx;
    logic [8:0] best_sw;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    zcm_selector i_zcm_selector (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ue_a(ue[0]), .ue_b(ue[1]), .ue_c(ue[2]),
        .il_a(il[0]), .il_b(il[1]), .il_c(il[2]),
        .il_ref_a(ir[0]), .il_ref_b(ir[1]), .il_ref_c(ir[2]),
        .isp_a(isp[0]), .isp_b(isp[1]), .isp_c(isp[2]),
        .is_ref_a(sr[0]), .is_ref_b(sr[1]), .is_ref_c(sr[2]),
        .k_volt(kv), .k_load(kl), .k_src(ks), .lambda_w(lam),
        .done(done), .best_idx(best_idx), .best_sw(best_sw)
    );

    // Candidate routing from R1: input phase for outputs A, B, C.
    localparam int SRC [6][3] = '{'{0,1,2}, '{0,2,1}, '{2,0,1}, '{1,0,2}, '{1,2,0}, '{2,1,0}};

    // ue0..2, il0..2, ir0..2, isp0..2, sr0..2, kv, kl, ks, lam
    localparam int NV = 6;
    localparam int VEC [NV][19] = '{
        '{1200,-600,-600, 300,-150,-150, 350,-100,-250, 40,-20,-20, 60,-30,-30, 900, 15000, 8000, 8192},
        '{-800,1100,-300, -200,400,-200, 0,500,-500, 10,10,-20, -50,100,-50, 1500, 14000, 12000, 8192},
        '{500,500,-1000, 100,-300,200, 250,250,-500, 0,0,0, 100,-300,200, 2000, 12000, 16384, 4096},
        '{0,900,-900, 700,-350,-350, -400,800,-400, 30,-60,30, 0,0,0, 1200, 16000, 6000, 16384},
        '{-1500,700,800, 50,50,-100, -600,300,300, 5,5,-10, 20,-40,20, 3000, 10000, 9000, 0},
        '{2000,-1000,-1000, -500,250,250, 600,-1300,700, -100,50,50, -300,150,150, 2500, 15500, 16000, 32767}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_sw(input int c);
        logic [8:0] m = '0;
        for (int j = 0; j < 3; j++) m[3*j + SRC[c][j]] = 1'b1;
        return m;
    endfunction

    function automatic longint f_alpha(input longint x0, input longint x1, input longint x2);
        return ((2*x0 - x1 - x2) * 5461) >>> 14;
    endfunction

    function automatic longint f_beta(input longint x1, input longint x2);
        return ((x1 - x2) * 9459) >>> 14;
    endfunction

    // Expected winner from R2..R7.
    function automatic int model();
        longint best = 0;
        int bi = 0;
        for (int c = 0; c < 6; c++) begin
            longint eo [3], es [3], iev [3];
            longint la, lb, sa, sb, cost;
            for (int j = 0; j < 3; j++) iev[SRC[c][j]] = longint'(il[j]);
            for (int j = 0; j < 3; j++) begin
                eo[j] = ((longint'(kv) * longint'(ue[SRC[c][j]]) + longint'(kl) * longint'(il[j])) >>> 14)
                        - longint'(ir[j]);
                es[j] = longint'(isp[j]) + ((longint'(ks) * iev[j]) >>> 14) - longint'(sr[j]);
            end
            la = f_alpha(eo[0], eo[1], eo[2]); lb = f_beta(eo[1], eo[2]);
            sa = f_alpha(es[0], es[1], es[2]); sb = f_beta(es[1], es[2]);
            cost = la*la + lb*lb + ((longint'(lam) * (sa*sa + sb*sb)) >>> 14);
            if (c == 0 || cost < best) begin best = cost; bi = c; end
        end
        return bi;
    endfunction

    task automatic load_vec(input int v);
        for (int j = 0; j < 3; j++) begin
            ue[j] = 16'(VEC[v][j]);     il[j] = 16'(VEC[v][3+j]);
            ir[j] = 16'(VEC[v][6+j]);   isp[j] = 16'(VEC[v][9+j]);
            sr[j] = 16'(VEC[v][12+j]);
        end
        kv = 16'(VEC[v][15]); kl = 16'(VEC[v][16]);
        ks = 16'(VEC[v][17]); lam = 16'(VEC[v][18]);
    endtask

    // Pulse start, wait for done; returns cycles from the accepting edge.
    task automatic launch(output int lat);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Load references equal to the voltages routed by candidate p (unit gain, lambda 0).
    task automatic target(input int p);
        kv = 16'sd16384; kl = '0; ks = '0; lam = '0;
        for (int j = 0; j < 3; j++) begin
            il[j] = 16'sd0; isp[j] = 16'sd0; sr[j] = 16'sd0;
            ir[j] = ue[SRC[p][j]];
        end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, e, dcount, idx_hold;
        for (int j = 0; j < 3; j++) begin
            ue[j] = '0; il[j] = '0; ir[j] = '0; isp[j] = '0; sr[j] = '0;
        end
        kv = '0; kl = '0; ks = '0; lam = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(done == 1'b0, "R10 done", done, 0);
        check(best_idx == 3'd0 && best_sw == 9'd0, "R10 outputs", {best_idx, best_sw}, 0);
        rst_n = 1'b1;

        // R3 R5 R6 R7: general vectors against the model
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            e = model();
            launch(lat);
            check(lat == 6, "R8 latency", lat, 6);
            check(best_idx == 3'(e), "R6 winner", best_idx, e);
            check(best_sw == exp_sw(e), "R1 matrix", best_sw, exp_sw(e));
        end

        // R1 R2: each candidate uniquely matched by its routed references
        ue[0] = 16'sd1000; ue[1] = -16'sd300; ue[2] = 16'sd200;
        for (int p = 0; p < 6; p++) begin
            target(p);
            launch(lat);
            check(best_idx == 3'(p), "R2 routed target", best_idx, p);
            check(best_sw == exp_sw(p), "R1 switch matrix", best_sw, exp_sw(p));
        end

        // R7: ties go to the lower index
        ue[0] = 16'sd400; ue[1] = 16'sd400; ue[2] = -16'sd800;
        target(0); launch(lat);
        check(best_idx == 3'd0, "R7 tie 0/3", best_idx, 0);
        target(1); launch(lat);
        check(best_idx == 3'd1, "R7 tie 1/4", best_idx, 1);
        target(2); launch(lat);
        check(best_idx == 3'd2, "R7 tie 2/5", best_idx, 2);
        for (int j = 0; j < 3; j++) begin ue[j] = '0; ir[j] = '0; end
        launch(lat);
        check(best_idx == 3'd0, "R7 all equal", best_idx, 0);

        // R4: source term alone decides, matched for candidate 4 (bca)
        kv = '0; kl = '0; ks = 16'sd16384; lam = 16'd16384;
        il[0] = 16'sd700; il[1] = -16'sd250; il[2] = -16'sd450;
        for (int j = 0; j < 3; j++) begin ir[j] = '0; isp[j] = '0; end
        sr[1] = il[0]; sr[2] = il[1]; sr[0] = il[2];
        launch(lat);
        check(best_idx == 3'd4, "R4 source routing", best_idx, 4);

        // R9: capture at start, later changes and re-start ignored
        ue[0] = 16'sd1000; ue[1] = -16'sd300; ue[2] = 16'sd200;
        target(2);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        target(5);
        dcount = 0; lat = 0;
        for (int k = 1; k <= 12; k++) begin
            if (k == 2) start = 1'b1;
            if (k == 3) start = 1'b0;
            @(negedge clk);
            if (done) begin dcount++; lat = k; end
        end
        check(dcount == 1, "R9 single done", dcount, 1);
        check(lat == 6, "R9 done cycle", lat, 6);
        check(best_idx == 3'd2, "R9 captured inputs", best_idx, 2);

        // R8: outputs hold between pulses while inputs move
        idx_hold = best_idx;
        target(0);
        repeat (5) @(negedge clk);
        check(best_idx == 3'(idx_hold) && done == 1'b0, "R8 hold", best_idx, idx_hold);

        // R10: reset after activity clears results
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check(best_idx == 3'd0 && best_sw == 9'd0 && done == 1'b0, "R10 re-reset",
              {best_idx, best_sw}, 0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule